// File: doc/BRIEF.md
# Programmable sample clock generator

This block derives a sample-rate strobe from a 24.576 MHz master clock. A rate word, programmed directly in hertz, is added to a fractional phase accumulator on every master clock. The accumulator wraps at 24,576,000, and each wrap produces a one-clock strobe. At that master clock, one unit of the rate word is exactly one hertz of strobe rate.

A second register requests a phase shift of the strobe. It holds a direction flag and an 8-bit magnitude. The magnitude is consumed one unit at a time, once every eight master clocks. Each unit moves the accumulator by 1/3000 of its modulus, which is 0.12 degrees of the sample period. A unit moves the accumulator forward for an advance and backward for a retard. Reading the phase register shows how much shift is still pending.

Software reaches both registers through a single-cycle write port and a combinational read port, using a one-bit address. An asynchronous active-low reset and a synchronous active-low power-down input both force the registers back to their defaults.

Top module: `sample_clkgen`

## Requirements
- R1: After reset, the rate register (address 0) reads 0xBB80, the phase register (address 1) reads 0x00FF, and `sample_stb` is low.
- R2: A write to address 0 stores the rate word clamped to the range 0x0FA0..0xD2F0. Values below the range store 0x0FA0, values above it store 0xD2F0, and in-range values are stored unchanged.
- R3: While `pwr_n` is low, both registers read their defaults (0xBB80 and 0x00FF) and writes are ignored. The accumulator and the step prescaler are cleared, and no strobe is produced.
- R4: A read of address 1 returns the direction in bit 8 (0 = advance, 1 = retard) and the pending magnitude in bits 7:0, with bits 15:9 reading zero. Written values of bits 15:9 are discarded.
- R5: The accumulator adds the current rate word every clock. When the sum reaches 24,576,000 or more, the modulus is subtracted and `sample_stb` is high for exactly the following clock. With no pending phase and rate 48000, strobes are exactly 512 clocks apart.
- R6: While the magnitude is nonzero, it decreases by one on every eighth clock after reset or power-up (prescaler phase 7 of 0..7). It stops at zero.
- R7: On each decrement clock, 8192 is also added to the accumulator for an advance. For a retard, 8192 is subtracted, and the result is held at 0 when it would go negative.
- R8: A write to address 1 loads the direction and the magnitude. On that clock, no phase step is taken and no decrement occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24.576 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Synchronous active-low power-down |
| reg_we | input | 1 | Register write enable, one clock per write |
| reg_addr | input | 1 | Register select: 0 = rate, 1 = phase |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| sample_stb | output | 1 | One-clock sample strobe |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that rate words of any 16-bit value are clamped before use. Because of the clamp, the per-clock increment is always far below the modulus, so the accumulator stays under the modulus and two strobes can never fall on adjacent clocks. The stimulus changes inputs two nanoseconds after a rising edge. Random rate words cover the whole 16-bit space, so clamping is exercised at both limits. Power-down pulses and phase writes land on arbitrary prescaler phases, so write-versus-step collisions and saturating retards occur without breaking those assumptions.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   typedef enum logic {
      DIR_ADVANCE = 1'b0,
      DIR_RETARD  = 1'b1
   } phase_dir_e;

   typedef struct packed {
      logic       active;
      phase_dir_e dir;
   } phase_step_t;

   function automatic logic [15:0] clamp_word(input logic [15:0] w,
                                              input logic [15:0] lo,
                                              input logic [15:0] hi);
      if (w < lo)      return lo;
      else if (w > hi) return hi;
      else             return w;
   endfunction

endpackage

// File: rtl/sclk_rate_reg.sv
module sclk_rate_reg #(
   parameter int REG_W    = 16,
   parameter int RATE_MIN = 4000,
   parameter int RATE_MAX = 54000,
   parameter int RATE_RST = 48000,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rate_q
);
   import sclk_pkg::*;

   localparam logic [REG_W-1:0] LO_V  = REG_W'(RATE_MIN);
   localparam logic [REG_W-1:0] HI_V  = REG_W'(RATE_MAX);
   localparam logic [REG_W-1:0] RST_V = REG_W'(RATE_RST);

   logic [REG_W-1:0] wr_fit;

   generate
      if (CLAMP_EN) begin : g_clamp
         if (REG_W == 16) begin : g_w16
            assign wr_fit = clamp_word(wr_data, LO_V, HI_V);
         end else begin : g_wn
            always_comb begin
               if (wr_data < LO_V)      wr_fit = LO_V;
               else if (wr_data > HI_V) wr_fit = HI_V;
               else                     wr_fit = wr_data;
            end
         end
      end else begin : g_pass
         assign wr_fit = wr_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rate_q <= RST_V;
      else if (!pwr_n) rate_q <= RST_V;
      else if (wr_en)  rate_q <= wr_fit;
   end

endmodule

// File: rtl/sclk_phase_ctl.sv
module sclk_phase_ctl #(
   parameter int         MAG_W    = 8,
   parameter int         STEP_DIV = 8,
   parameter logic       RST_DIR  = 1'b0,
   parameter int         RST_MAG  = 255
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pwr_n,
   input  logic                  wr_en,
   input  logic                  wr_dir,
   input  logic [MAG_W-1:0]      wr_mag,
   output logic                  dir_q,
   output logic [MAG_W-1:0]      mag_q,
   output sclk_pkg::phase_step_t step_o
);
   import sclk_pkg::*;

   localparam int               CNT_W   = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
   localparam logic [MAG_W-1:0] RST_M_V = MAG_W'(RST_MAG);

   logic tick;
   logic take_step;

   generate
      if (STEP_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (!pwr_n)       cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate

   assign take_step     = tick && (mag_q != '0) && !wr_en;
   assign step_o.active = take_step;
   assign step_o.dir    = phase_dir_e'(dir_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= RST_DIR;
         mag_q <= RST_M_V;
      end else if (!pwr_n) begin
         dir_q <= RST_DIR;
         mag_q <= RST_M_V;
      end else if (wr_en) begin
         dir_q <= wr_dir;
         mag_q <= wr_mag;
      end else if (take_step) begin
         mag_q <= mag_q - 1'b1;
      end
   end

endmodule

// File: rtl/sclk_phase_acc.sv
module sclk_phase_acc #(
   parameter int RATE_W     = 16,
   parameter int ACC_MOD    = 24576000,
   parameter int PHASE_STEP = 8192,
   parameter int ACC_W      = $clog2(2 * ACC_MOD)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pwr_n,
   input  logic [RATE_W-1:0]     rate,
   input  sclk_pkg::phase_step_t step,
   output logic [ACC_W-1:0]      acc_q,
   output logic                  stb_q
);
   import sclk_pkg::*;

   localparam logic [ACC_W-1:0] MOD_V  = ACC_W'(ACC_MOD);
   localparam logic [ACC_W-1:0] STEP_V = ACC_W'(PHASE_STEP);

   logic [ACC_W-1:0] base_sum;
   logic [ACC_W-1:0] adj_sum;
   logic [ACC_W-1:0] acc_nxt;
   logic             wrap;

   always_comb begin
      base_sum = acc_q + ACC_W'(rate);
      adj_sum  = base_sum;
      if (step.active) begin
         if (step.dir == DIR_ADVANCE) begin
            adj_sum = base_sum + STEP_V;
         end else if (base_sum >= STEP_V) begin
            adj_sum = base_sum - STEP_V;
         end else begin
            adj_sum = '0;
         end
      end
      wrap    = (adj_sum >= MOD_V);
      acc_nxt = wrap ? (adj_sum - MOD_V) : adj_sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         stb_q <= 1'b0;
      end else if (!pwr_n) begin
         acc_q <= '0;
         stb_q <= 1'b0;
      end else begin
         acc_q <= acc_nxt;
         stb_q <= wrap;
      end
   end

endmodule

// File: rtl/sample_clkgen.sv
module sample_clkgen #(
   parameter int REG_W      = 16,
   parameter int MAG_W      = 8,
   parameter int STEP_DIV   = 8,
   parameter int ACC_MOD    = 24576000,
   parameter int PHASE_STEP = 8192,
   parameter int RATE_MIN   = 4000,
   parameter int RATE_MAX   = 54000,
   parameter int RATE_RST   = 48000,
   parameter int PHASE_RST  = 255,
   parameter bit CLAMP_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_n,
   input  logic             reg_we,
   input  logic             reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             sample_stb
);
   import sclk_pkg::*;

   localparam int   ACC_W    = $clog2(2 * ACC_MOD);
   localparam logic A_RATE   = 1'b0;
   localparam logic A_PHASE  = 1'b1;
   localparam int   RSV_W    = REG_W - MAG_W - 1;
   localparam logic RST_DIR  = PHASE_RST[MAG_W];
   localparam int   RST_MAG  = PHASE_RST % (1 << MAG_W);

   generate
      if (RSV_W < 0) begin : g_err_fit
         $error("phase field does not fit in the register width");
      end
      if (STEP_DIV < 1) begin : g_err_div
         $error("step divider must be at least one");
      end
      if (RATE_MIN > RATE_RST || RATE_RST > RATE_MAX) begin : g_err_rst
         $error("reset rate lies outside the clamp window");
      end
      if (RATE_MAX + PHASE_STEP >= ACC_MOD) begin : g_err_mod
         $error("one clock may not cross the modulus twice");
      end
      if (RATE_MAX >= (1 << REG_W)) begin : g_err_max
         $error("rate limit exceeds the register width");
      end
   endgenerate

   logic             wr_rate;
   logic             wr_phase;
   logic [REG_W-1:0] rate_q;
   logic             dir_q;
   logic [MAG_W-1:0] mag_q;
   logic [ACC_W-1:0] acc_q;
   phase_step_t      step;

   assign wr_rate  = reg_we && (reg_addr == A_RATE);
   assign wr_phase = reg_we && (reg_addr == A_PHASE);

   sclk_rate_reg #(
      .REG_W    (REG_W),
      .RATE_MIN (RATE_MIN),
      .RATE_MAX (RATE_MAX),
      .RATE_RST (RATE_RST),
      .CLAMP_EN (CLAMP_EN)
   ) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_n   (pwr_n),
      .wr_en   (wr_rate),
      .wr_data (reg_wdata),
      .rate_q  (rate_q)
   );

   sclk_phase_ctl #(
      .MAG_W    (MAG_W),
      .STEP_DIV (STEP_DIV),
      .RST_DIR  (RST_DIR),
      .RST_MAG  (RST_MAG)
   ) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_n  (pwr_n),
      .wr_en  (wr_phase),
      .wr_dir (reg_wdata[MAG_W]),
      .wr_mag (reg_wdata[MAG_W-1:0]),
      .dir_q  (dir_q),
      .mag_q  (mag_q),
      .step_o (step)
   );

   sclk_phase_acc #(
      .RATE_W     (REG_W),
      .ACC_MOD    (ACC_MOD),
      .PHASE_STEP (PHASE_STEP),
      .ACC_W      (ACC_W)
   ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .pwr_n (pwr_n),
      .rate  (rate_q),
      .step  (step),
      .acc_q (acc_q),
      .stb_q (sample_stb)
   );

   generate
      if (RSV_W > 0) begin : g_rsv
         assign reg_rdata = (reg_addr == A_PHASE) ? {{RSV_W{1'b0}}, dir_q, mag_q} : rate_q;
      end else begin : g_norsv
         assign reg_rdata = (reg_addr == A_PHASE) ? {dir_q, mag_q} : rate_q;
      end
   endgenerate

endmodule

// File: rtl/sample_clkgen_chk.sv
module sample_clkgen_chk #(
   parameter int REG_W    = 16,
   parameter int MAG_W    = 8,
   parameter int ACC_MOD  = 24576000,
   parameter int RATE_MIN = 4000,
   parameter int RATE_MAX = 54000,
   parameter int RATE_RST = 48000,
   parameter int RST_MAG  = 255,
   parameter int ACC_W    = $clog2(2 * ACC_MOD)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_n,
   input logic             reg_we,
   input logic             reg_addr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             sample_stb,
   input logic [REG_W-1:0] rate_q,
   input logic [MAG_W-1:0] mag_q,
   input logic [ACC_W-1:0] acc_q
);

   p_rate_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q >= REG_W'(RATE_MIN)) && (rate_q <= REG_W'(RATE_MAX)));

   p_pwr_defaults_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_n |=> (rate_q == REG_W'(RATE_RST)) && (mag_q == MAG_W'(RST_MAG)) && !sample_stb);

   p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr |-> (reg_rdata[REG_W-1:MAG_W+1] == '0));

   p_stb_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   p_mag_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_n && !(reg_we && reg_addr)) |=>
         ((mag_q == $past(mag_q)) || (mag_q == $past(mag_q) - 1'b1)));

   p_acc_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < ACC_W'(ACC_MOD));

   p_phase_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_n && reg_we && reg_addr) |=> (mag_q == $past(reg_wdata[MAG_W-1:0])));

endmodule

bind sample_clkgen sample_clkgen_chk #(
   .REG_W    (REG_W),
   .MAG_W    (MAG_W),
   .ACC_MOD  (ACC_MOD),
   .RATE_MIN (RATE_MIN),
   .RATE_MAX (RATE_MAX),
   .RATE_RST (RATE_RST),
   .RST_MAG  (PHASE_RST % (1 << MAG_W)),
   .ACC_W    ($clog2(2 * ACC_MOD))
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_n      (pwr_n),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .sample_stb (sample_stb),
   .rate_q     (rate_q),
   .mag_q      (mag_q),
   .acc_q      (acc_q)
);

// File: tb/sample_clkgen_tb.sv
module sample_clkgen_tb;

   localparam int  MOD   = 24576000;
   localparam int  STEPV = 8192;
   localparam int  LIMIT = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_n = 1'b1;
   logic        reg_we = 1'b0;
   logic        reg_addr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sample_stb;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   sample_clkgen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_n      (pwr_n),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .sample_stb (sample_stb)
   );

   always #4 clk = ~clk;

   // reference state, built from the requirements
   int     m_rate, m_mag, m_dir, m_cnt;
   longint m_acc;
   bit     m_stb;

   function automatic int fit_rate(input int w);
      if (w < 4000)  return 4000;
      if (w > 54000) return 54000;
      return w;
   endfunction

   function automatic int model_read(input bit a);
      if (a) return (m_dir << 8) | m_mag;
      return m_rate;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rate = 48000; m_mag = 255; m_dir = 0; m_cnt = 0; m_acc = 0; m_stb = 0;
      end else if (!pwr_n) begin
         m_rate = 48000; m_mag = 255; m_dir = 0; m_cnt = 0; m_acc = 0; m_stb = 0;
      end else begin
         bit     tick, pw, stepping;
         longint s;
         tick     = (m_cnt == 7);
         m_cnt    = (m_cnt + 1) % 8;
         pw       = reg_we && reg_addr;
         stepping = tick && (m_mag != 0) && !pw;
         s = m_acc + m_rate;
         if (stepping) begin
            if (m_dir == 0) s = s + STEPV;
            else            s = (s < STEPV) ? 0 : s - STEPV;
            m_mag = m_mag - 1;
         end
         m_stb = (s >= MOD);
         if (m_stb) s = s - MOD;
         m_acc = s;
         if (pw) begin
            m_dir = reg_wdata[8];
            m_mag = reg_wdata[7:0];
         end
         if (reg_we && !reg_addr) m_rate = fit_rate(reg_wdata);
      end
   end

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5/R7 strobe vs model", sample_stb, m_stb);
         if (reg_addr) chk("R4/R6 phase readback vs model", reg_rdata, model_read(1'b1));
         else          chk("R2 rate readback vs model", reg_rdata, model_read(1'b0));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == LIMIT && !done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input bit a, input logic [15:0] d);
      @(posedge clk); #2;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #2;
      reg_we = 1'b0;
   endtask

   task automatic rdchk(input string tag, input bit a, input int exp);
      @(posedge clk); #2;
      reg_addr = a;
      @(negedge clk);
      chk(tag, reg_rdata, exp);
   endtask

   task automatic pwr_cycle(input int n);
      @(posedge clk); #2;
      pwr_n = 1'b0;
      idle(n);
      pwr_n = 1'b1;
   endtask

   initial begin
      int unsigned seed0;
      int gap;
      seed0 = $urandom(32'd20240611);
      idle(3);
      rst_n = 1'b1;

      // R1 defaults
      @(negedge clk);
      chk("R1 strobe after reset", sample_stb, 0);
      rdchk("R1 rate default", 1'b0, 16'hBB80);
      rdchk("R1 phase default", 1'b1, 16'h00FF);

      // R2 clamping
      wr(1'b0, 16'h0000); rdchk("R2 clamp low", 1'b0, 16'h0FA0);
      wr(1'b0, 16'hFFFF); rdchk("R2 clamp high", 1'b0, 16'hD2F0);
      wr(1'b0, 16'h0F9F); rdchk("R2 one below min", 1'b0, 16'h0FA0);
      wr(1'b0, 16'hD2F1); rdchk("R2 one above max", 1'b0, 16'hD2F0);
      wr(1'b0, 16'h0FA0); rdchk("R2 exact min", 1'b0, 16'h0FA0);
      wr(1'b0, 16'h1234); rdchk("R2 in range", 1'b0, 16'h1234);

      // R4 reserved bits and field layout
      wr(1'b1, 16'hFE05); rdchk("R4 reserved dropped", 1'b1, 16'h0005);
      wr(1'b1, 16'h0137); rdchk("R4 retard field", 1'b1, 16'h0137);

      // R3 power-down holds defaults, ignores writes
      @(posedge clk); #2;
      pwr_n = 1'b0;
      wr(1'b0, 16'h2000);
      wr(1'b1, 16'h0111);
      rdchk("R3 rate held default", 1'b0, 16'hBB80);
      rdchk("R3 phase held default", 1'b1, 16'h00FF);
      @(negedge clk);
      chk("R3 no strobe in power-down", sample_stb, 0);
      pwr_n = 1'b1;

      // R8 write on a step clock: prescaler phase 7 is 8 clocks after power-up
      pwr_cycle(2);
      idle(7);
      reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h0010;
      @(posedge clk); #2;
      reg_we = 1'b0;
      @(negedge clk);
      chk("R8 loaded without decrement", reg_rdata, 16'h0010);

      // R6 countdown to zero and stop
      wr(1'b1, 16'h0004);
      idle(40);
      rdchk("R6 magnitude drained", 1'b1, 16'h0000);
      idle(16);
      rdchk("R6 stays at zero", 1'b1, 16'h0000);

      // R5 exact interval at 48 kHz with no pending phase
      wr(1'b0, 16'hBB80);
      begin
         int n;
         do @(negedge clk); while (!sample_stb);
         n = 0;
         do begin @(negedge clk); n++; end while (!sample_stb);
         chk("R5 interval at 48000", n, 512);
      end

      // R7 saturating retard at minimum rate
      pwr_cycle(2);
      wr(1'b0, 16'h0FA0);
      wr(1'b1, 16'h01FF);
      idle(3000);
      wr(1'b1, 16'h00C8);
      idle(2000);

      // constrained random mix
      for (int i = 0; i < 45; i++) begin
         logic [15:0] d;
         d = 16'($urandom);
         case ($urandom % 5)
            0: wr(1'b0, d);
            1: wr(1'b1, d);
            2: begin wr(1'b0, d); wr(1'b1, 16'($urandom)); end
            3: pwr_cycle(1 + $urandom % 6);
            default: begin
               @(posedge clk); #2;
               reg_addr = $urandom % 2;
            end
         endcase
         gap = 20 + $urandom % 1500;
         idle(gap);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule